// File: doc/BRIEF.md
# Indirect-Access Memory Controller Register Block

This block holds the configuration and status registers of a memory controller behind a pair of register-bus locations. One location is a pointer register and the other is a data window. Software writes the offset of an inner register into the pointer, then reads or writes the window to reach that register. The register bus carries a register number, a write strobe and 32-bit write data, and returns 32-bit read data. Reads are combinational. Writes take effect on the clock edge on which the strobe is high.

Every inner register applies its own write mask. Two error-status words are cleared by writing ones. The status word cannot be written; its two upper bits record edges of the configuration word's enable and self-refresh bits rather than their levels. A nonzero ECC error-status word holds a level interrupt high.

The four bank words and the global enable bit are brought out as outputs for the address-decode logic that sits next to the block. Bank decoding and the memory datapath are not part of it.

Top module: `mcfg_regs`

## Requirements
- R1: The pointer register sits at bus number 0x010 and reads back all 32 bits last written. A read of any bus number other than 0x010 or 0x011 returns zero, and a write to such a number changes no register.
- R2: A window access at bus number 0x011 reaches the inner register whose offset equals the full 32-bit pointer value. The error-address word at offset 0x10 stores and returns all 32 bits.
- R3: The error-status words at offsets 0x00 and 0x08 are write-one-to-clear: each 1 written clears the matching stored bit. Both read zero after reset.
- R4: A write to the config word at offset 0x20 stores the data ANDed with 0xFFE00000. Output ctlEnable equals config bit 31. A 0-to-1 change of bit 31 clears status bit 31, and a 1-to-0 change sets it.
- R5: A 0-to-1 change of config bit 30 sets status bit 30, and a 1-to-0 change clears it. A config write that leaves bits 31 and 30 unchanged leaves the status word unchanged.
- R6: The status word at offset 0x24 is read-only, and writes to it are ignored.
- R7: Offset 0x30 (refresh) stores the data ANDed with 0x3FF80000. Offset 0x94 (ECC config) stores the data ANDed with 0x00F00000. Offset 0x34 (power management) stores (data AND 0xF8000000) OR 0x07C00000.
- R8: Bank word i, at offset 0x40+4*i for i in 0..3, stores the data ANDed with 0xFFDEE001. It appears on bankWords bits [32*i+31 : 32*i].
- R9: Offset 0x98 (ECC error status) stores the data ANDed with 0xFFF0F000. eccIrq is high while that word is nonzero and low while it is zero.
- R10: A window read of the timing offset 0x80, or of any offset not listed here, returns 0xFFFFFFFF.
- R11: Synchronous active-high reset sets power management to 0x07C00000, refresh to 0x05F00000 and config to 0x00800000. It clears every other register, eccIrq, ctlEnable and bankWords.
- R12: busRdata follows busNum and the register contents combinationally. A window write is first visible on busRdata after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busNum | input | 10 | Register number on the bus |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current busNum |
| bankWords | output | 128 | Bank words 0..3, bank i at bits [32*i+31:32*i] |
| ctlEnable | output | 1 | Global enable, config bit 31 |
| eccIrq | output | 1 | Level interrupt, high while ECC error status is nonzero |

## Verification
The bench targets the edge-tracking status bits. It drives the enable and self-refresh bits through rise, fall and repeated-value writes. A design that copied levels would show status bit 31 set while enabled, and a design that ignored repeats incorrectly would flip a bit on an identical write. It writes all ones into every masked register and reads back each mask; a wrong mask, or a power-management word missing its forced field, shows up as a different read value. It also probes the window for offsets outside the register map and for unmatched bus numbers, where an aliasing decoder would return stored data instead of all ones or zero. It checks that write-one-to-clear words and the read-only status word cannot be loaded by an all-ones write.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

  localparam int DATA_W   = 32;
  localparam int BANK_CNT = 4;

  // inner offsets held in the pointer register
  localparam logic [DATA_W-1:0] OFF_ERR0     = 32'h00;
  localparam logic [DATA_W-1:0] OFF_ERR1     = 32'h08;
  localparam logic [DATA_W-1:0] OFF_ERRADDR  = 32'h10;
  localparam logic [DATA_W-1:0] OFF_CFG      = 32'h20;
  localparam logic [DATA_W-1:0] OFF_STATUS   = 32'h24;
  localparam logic [DATA_W-1:0] OFF_REFRESH  = 32'h30;
  localparam logic [DATA_W-1:0] OFF_PWR      = 32'h34;
  localparam logic [DATA_W-1:0] OFF_BANK0    = 32'h40;
  localparam logic [DATA_W-1:0] OFF_BANKSTEP = 32'h04;
  localparam logic [DATA_W-1:0] OFF_ECCCFG   = 32'h94;
  localparam logic [DATA_W-1:0] OFF_ECCESR   = 32'h98;

  // per-register write masks
  localparam logic [DATA_W-1:0] MSK_CFG      = 32'hFFE0_0000;
  localparam logic [DATA_W-1:0] MSK_REFRESH  = 32'h3FF8_0000;
  localparam logic [DATA_W-1:0] MSK_PWR      = 32'hF800_0000;
  localparam logic [DATA_W-1:0] FIX_PWR      = 32'h07C0_0000;
  localparam logic [DATA_W-1:0] MSK_BANK     = 32'hFFDE_E001;
  localparam logic [DATA_W-1:0] MSK_ECCCFG   = 32'h00F0_0000;
  localparam logic [DATA_W-1:0] MSK_ECCESR   = 32'hFFF0_F000;

  // reset values
  localparam logic [DATA_W-1:0] RST_CFG      = 32'h0080_0000;
  localparam logic [DATA_W-1:0] RST_REFRESH  = 32'h05F0_0000;
  localparam logic [DATA_W-1:0] RST_PWR      = 32'h07C0_0000;

  localparam logic [DATA_W-1:0] RD_UNMAPPED  = '1;

  localparam int BIT_EN   = 31;
  localparam int BIT_SREF = 30;

  typedef struct packed {
    logic                err0Clr;
    logic                err1Clr;
    logic                errAddrWr;
    logic                cfgWr;
    logic                refreshWr;
    logic                pwrWr;
    logic                eccCfgWr;
    logic                eccEsrWr;
    logic [BANK_CNT-1:0] bankWr;
  } regStrobe_t;

endpackage

// File: rtl/mcfg_ctrl.sv
module mcfg_ctrl
  import mcfg_pkg::*;
#(
  parameter int                BUS_W    = 10,
  parameter logic [BUS_W-1:0]  NUM_PTR  = 10'h010,
  parameter logic [BUS_W-1:0]  NUM_WIN  = 10'h011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  busNum,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] innerAddr,
  output logic              rdPtr,
  output logic              rdWin,
  output regStrobe_t        stb
);

  logic [DATA_W-1:0] ptrQ;
  logic              ptrHit;
  logic              winHit;
  logic              winWr;

  assign ptrHit    = (busNum == NUM_PTR);
  assign winHit    = (busNum == NUM_WIN);
  assign winWr     = busWr && winHit;
  assign innerAddr = ptrQ;
  assign rdPtr     = ptrHit;
  assign rdWin     = winHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptrQ <= '0;
    end else if (busWr && ptrHit) begin
      ptrQ <= busWdata;
    end
  end

  always_comb begin
    stb           = '0;
    stb.err0Clr   = winWr && (ptrQ == OFF_ERR0);
    stb.err1Clr   = winWr && (ptrQ == OFF_ERR1);
    stb.errAddrWr = winWr && (ptrQ == OFF_ERRADDR);
    stb.cfgWr     = winWr && (ptrQ == OFF_CFG);
    stb.refreshWr = winWr && (ptrQ == OFF_REFRESH);
    stb.pwrWr     = winWr && (ptrQ == OFF_PWR);
    stb.eccCfgWr  = winWr && (ptrQ == OFF_ECCCFG);
    stb.eccEsrWr  = winWr && (ptrQ == OFF_ECCESR);
    for (int i = 0; i < BANK_CNT; i++) begin
      stb.bankWr[i] = winWr && (ptrQ == OFF_BANK0 + OFF_BANKSTEP * DATA_W'(i));
    end
  end

  // R2: a window write reaches at most one inner register
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));

  // R1: a write to any other bus number leaves the pointer alone
  a_r1_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !(busWr && ptrHit) |=> $stable(ptrQ));

endmodule

// File: rtl/mcfg_dpath.sv
module mcfg_dpath
  import mcfg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  regStrobe_t                 stb,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W-1:0]          innerAddr,
  input  logic                       rdPtr,
  input  logic                       rdWin,
  output logic [DATA_W-1:0]          rdata,
  output logic [BANK_CNT*DATA_W-1:0] bankWords,
  output logic                       ctlEnable,
  output logic                       eccIrq
);

  logic [DATA_W-1:0] err0Q, err1Q, errAddrQ, cfgQ;
  logic [DATA_W-1:0] refreshQ, pwrQ, eccCfgQ, eccEsrQ;
  logic [DATA_W-1:0] bankQ [BANK_CNT];
  logic [1:0]        stsQ;   // status bits 31 and 30
  logic [DATA_W-1:0] cfgNext;
  logic [DATA_W-1:0] stsWord;

  assign cfgNext = wdata & MSK_CFG;
  assign stsWord = {stsQ, {(DATA_W-2){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      err0Q    <= '0;
      err1Q    <= '0;
      errAddrQ <= '0;
      cfgQ     <= RST_CFG;
      stsQ     <= '0;
      refreshQ <= RST_REFRESH;
      pwrQ     <= RST_PWR;
      eccCfgQ  <= '0;
      eccEsrQ  <= '0;
    end else begin
      if (stb.err0Clr)   err0Q    <= err0Q & ~wdata;
      if (stb.err1Clr)   err1Q    <= err1Q & ~wdata;
      if (stb.errAddrWr) errAddrQ <= wdata;
      if (stb.refreshWr) refreshQ <= wdata & MSK_REFRESH;
      if (stb.pwrWr)     pwrQ     <= (wdata & MSK_PWR) | FIX_PWR;
      if (stb.eccCfgWr)  eccCfgQ  <= wdata & MSK_ECCCFG;
      if (stb.eccEsrWr)  eccEsrQ  <= wdata & MSK_ECCESR;
      if (stb.cfgWr) begin
        cfgQ <= cfgNext;
        // enable edge: rise clears, fall sets
        if (!cfgQ[BIT_EN] && cfgNext[BIT_EN])      stsQ[1] <= 1'b0;
        else if (cfgQ[BIT_EN] && !cfgNext[BIT_EN]) stsQ[1] <= 1'b1;
        // self-refresh edge: rise sets, fall clears
        if (!cfgQ[BIT_SREF] && cfgNext[BIT_SREF])      stsQ[0] <= 1'b1;
        else if (cfgQ[BIT_SREF] && !cfgNext[BIT_SREF]) stsQ[0] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < BANK_CNT; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                bankQ[g] <= '0;
      else if (stb.bankWr[g]) bankQ[g] <= wdata & MSK_BANK;
    end
    assign bankWords[g*DATA_W +: DATA_W] = bankQ[g];

    // R8: stored bank word is the masked write data
    a_r8_bank_mask: assert property (@(posedge clk) disable iff (rst)
      stb.bankWr[g] |=> bankWords[g*DATA_W +: DATA_W] == ($past(wdata) & MSK_BANK));
  end

  assign ctlEnable = cfgQ[BIT_EN];
  assign eccIrq    = (eccEsrQ != '0);

  always_comb begin
    rdata = '0;
    if (rdPtr) begin
      rdata = innerAddr;
    end else if (rdWin) begin
      unique case (innerAddr)
        OFF_ERR0:    rdata = err0Q;
        OFF_ERR1:    rdata = err1Q;
        OFF_ERRADDR: rdata = errAddrQ;
        OFF_CFG:     rdata = cfgQ;
        OFF_STATUS:  rdata = stsWord;
        OFF_REFRESH: rdata = refreshQ;
        OFF_PWR:     rdata = pwrQ;
        OFF_ECCCFG:  rdata = eccCfgQ;
        OFF_ECCESR:  rdata = eccEsrQ;
        default:     rdata = RD_UNMAPPED;
      endcase
      for (int i = 0; i < BANK_CNT; i++) begin
        if (innerAddr == OFF_BANK0 + OFF_BANKSTEP * DATA_W'(i)) rdata = bankQ[i];
      end
    end
  end

  // R6: status only moves on a config write
  a_r6_status_ro: assert property (@(posedge clk) disable iff (rst)
    !stb.cfgWr |=> $stable(stsQ));

  // R4: enabling clears status bit 31 and raises ctlEnable
  a_r4_enable_rise: assert property (@(posedge clk) disable iff (rst)
    (stb.cfgWr && !ctlEnable && wdata[BIT_EN]) |=> (ctlEnable && !stsQ[1]));

  // R4: disabling sets status bit 31
  a_r4_enable_fall: assert property (@(posedge clk) disable iff (rst)
    (stb.cfgWr && ctlEnable && !wdata[BIT_EN]) |=> (!ctlEnable && stsQ[1]));

  // R9: writing a value with no bits in the mask drops the interrupt
  a_r9_irq_low: assert property (@(posedge clk) disable iff (rst)
    (stb.eccEsrWr && ((wdata & MSK_ECCESR) == '0)) |=> !eccIrq);

  // R9: writing a value with a bit in the mask raises the interrupt
  a_r9_irq_high: assert property (@(posedge clk) disable iff (rst)
    (stb.eccEsrWr && ((wdata & MSK_ECCESR) != '0)) |=> eccIrq);

  // R3: each written one is clear afterwards
  a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
    stb.err0Clr |=> ((err0Q & $past(wdata)) == '0));

endmodule

// File: rtl/mcfg_regs.sv
module mcfg_regs
  import mcfg_pkg::*;
#(
  parameter int               BUS_W   = 10,
  parameter logic [BUS_W-1:0] NUM_PTR = 10'h010,
  parameter logic [BUS_W-1:0] NUM_WIN = 10'h011
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [BUS_W-1:0]           busNum,
  input  logic                       busWr,
  input  logic [DATA_W-1:0]          busWdata,
  output logic [DATA_W-1:0]          busRdata,
  output logic [BANK_CNT*DATA_W-1:0] bankWords,
  output logic                       ctlEnable,
  output logic                       eccIrq
);

  regStrobe_t        stb;
  logic [DATA_W-1:0] innerAddr;
  logic              rdPtr;
  logic              rdWin;

  mcfg_ctrl #(
    .BUS_W   (BUS_W),
    .NUM_PTR (NUM_PTR),
    .NUM_WIN (NUM_WIN)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .busNum    (busNum),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .innerAddr (innerAddr),
    .rdPtr     (rdPtr),
    .rdWin     (rdWin),
    .stb       (stb)
  );

  mcfg_dpath dpath_i (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .wdata     (busWdata),
    .innerAddr (innerAddr),
    .rdPtr     (rdPtr),
    .rdWin     (rdWin),
    .rdata     (busRdata),
    .bankWords (bankWords),
    .ctlEnable (ctlEnable),
    .eccIrq    (eccIrq)
  );

endmodule

// File: tb/mcfg_regs_tb.sv
module mcfg_regs_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic [9:0]   busNum;
  logic         busWr;
  logic [31:0]  busWdata;
  logic [31:0]  busRdata;
  logic [127:0] bankWords;
  logic         ctlEnable;
  logic         eccIrq;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  mcfg_regs dut_i (
    .clk       (clk),
    .rst       (rst),
    .busNum    (busNum),
    .busWr     (busWr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .bankWords (bankWords),
    .ctlEnable (ctlEnable),
    .eccIrq    (eccIrq)
  );

  // entry: {tag[3:0], isWrite, busNum[9:0], data[31:0]}
  // isWrite=1: data is written; isWrite=0: data is the expected read value
  localparam int NV = 47;
  localparam logic [46:0] VEC [NV] = '{
    {4'd2,  1'b1, 10'h010, 32'h0000_0010},   // R2 error address
    {4'd2,  1'b1, 10'h011, 32'hDEAD_BEEF},
    {4'd2,  1'b0, 10'h011, 32'hDEAD_BEEF},
    {4'd3,  1'b1, 10'h010, 32'h0000_0000},   // R3 W1C words
    {4'd3,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd3,  1'b0, 10'h011, 32'h0000_0000},
    {4'd3,  1'b1, 10'h010, 32'h0000_0008},
    {4'd3,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd3,  1'b0, 10'h011, 32'h0000_0000},
    {4'd4,  1'b1, 10'h010, 32'h0000_0020},   // R4 config mask
    {4'd4,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd4,  1'b0, 10'h011, 32'hFFE0_0000},
    {4'd5,  1'b1, 10'h010, 32'h0000_0024},   // R5 bit30 rose
    {4'd5,  1'b0, 10'h011, 32'h4000_0000},
    {4'd6,  1'b1, 10'h011, 32'h1234_5678},   // R6 read-only
    {4'd6,  1'b0, 10'h011, 32'h4000_0000},
    {4'd4,  1'b1, 10'h010, 32'h0000_0020},   // R4 enable falls
    {4'd4,  1'b1, 10'h011, 32'h0000_0000},
    {4'd4,  1'b1, 10'h010, 32'h0000_0024},
    {4'd4,  1'b0, 10'h011, 32'h8000_0000},
    {4'd7,  1'b1, 10'h010, 32'h0000_0030},   // R7 refresh
    {4'd7,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd7,  1'b0, 10'h011, 32'h3FF8_0000},
    {4'd7,  1'b1, 10'h010, 32'h0000_0034},   // R7 power management
    {4'd7,  1'b1, 10'h011, 32'h0000_0000},
    {4'd7,  1'b0, 10'h011, 32'h07C0_0000},
    {4'd7,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd7,  1'b0, 10'h011, 32'hFFC0_0000},
    {4'd7,  1'b1, 10'h010, 32'h0000_0094},   // R7 ECC config
    {4'd7,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd7,  1'b0, 10'h011, 32'h00F0_0000},
    {4'd8,  1'b1, 10'h010, 32'h0000_0044},   // R8 bank 1
    {4'd8,  1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd8,  1'b0, 10'h011, 32'hFFDE_E001},
    {4'd9,  1'b1, 10'h010, 32'h0000_0098},   // R9 ECC error status
    {4'd9,  1'b1, 10'h011, 32'h0000_FFFF},
    {4'd9,  1'b0, 10'h011, 32'h0000_F000},
    {4'd10, 1'b1, 10'h010, 32'h0000_0080},   // R10 timing reads ones
    {4'd10, 1'b1, 10'h011, 32'hFFFF_FFFF},
    {4'd10, 1'b0, 10'h011, 32'hFFFF_FFFF},
    {4'd10, 1'b1, 10'h010, 32'h0000_0084},   // R10 hole in the map
    {4'd10, 1'b0, 10'h011, 32'hFFFF_FFFF},
    {4'd1,  1'b0, 10'h012, 32'h0000_0000},   // R1 other bus numbers
    {4'd1,  1'b0, 10'h00F, 32'h0000_0000},
    {4'd1,  1'b1, 10'h010, 32'hABCD_1234},   // R1 full-width pointer
    {4'd1,  1'b0, 10'h010, 32'hABCD_1234},
    {4'd10, 1'b0, 10'h011, 32'hFFFF_FFFF}    // R10 offset is full width
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic busWrite(input logic [9:0] num, input logic [31:0] data);
    busNum   = num;
    busWdata = data;
    busWr    = 1'b1;
    @(negedge clk);
    busWr    = 1'b0;
  endtask

  task automatic busRead(input logic [9:0] num, output logic [31:0] data);
    busNum = num;
    #1;
    data = busRdata;
  endtask

  task automatic winRead(input logic [31:0] off, output logic [31:0] data);
    busWrite(10'h010, off);
    busRead(10'h011, data);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst = 1'b1; busNum = '0; busWr = 1'b0; busWdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk("R11 eccIrq", {31'd0, eccIrq}, 32'd0);
    chk("R11 ctlEnable", {31'd0, ctlEnable}, 32'd0);
    chk("R11 bankWords", bankWords[31:0] | bankWords[63:32] | bankWords[95:64] | bankWords[127:96], 32'd0);
    busRead(10'h010, rd); chk("R11 pointer", rd, 32'd0);
    winRead(32'h20, rd); chk("R11 config", rd, 32'h0080_0000);
    winRead(32'h30, rd); chk("R11 refresh", rd, 32'h05F0_0000);
    winRead(32'h34, rd); chk("R11 power", rd, 32'h07C0_0000);
    winRead(32'h24, rd); chk("R11 status", rd, 32'd0);
    winRead(32'h98, rd); chk("R11 ecc status", rd, 32'd0);
    winRead(32'h10, rd); chk("R11 error address", rd, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) begin
        busWrite(VEC[i][41:32], VEC[i][31:0]);
      end else begin
        busRead(VEC[i][41:32], rd);
        chk($sformatf("R%0d vector %0d", VEC[i][46:43], i), rd, VEC[i][31:0]);
      end
    end

    // R9 interrupt level after ECC status F000
    chk("R9 irq high", {31'd0, eccIrq}, 32'd1);
    // R8 bank output slices
    chk("R8 bank1 slice", bankWords[63:32], 32'hFFDE_E001);
    chk("R8 bank0 slice", bankWords[31:0], 32'd0);
    busWrite(10'h010, 32'h98);
    busWrite(10'h011, 32'h0000_0FFF);   // no bits inside the mask
    chk("R9 irq low", {31'd0, eccIrq}, 32'd0);

    // R4 enable rise clears status bit 31
    busWrite(10'h010, 32'h20);
    busWrite(10'h011, 32'h8000_0000);
    chk("R4 ctlEnable high", {31'd0, ctlEnable}, 32'd1);
    winRead(32'h24, rd); chk("R4 status after enable", rd, 32'd0);
    // R5 same value again leaves status alone
    busWrite(10'h010, 32'h20);
    busWrite(10'h011, 32'h8000_0000);
    winRead(32'h24, rd); chk("R5 repeat write", rd, 32'd0);
    busWrite(10'h010, 32'h20);
    busWrite(10'h011, 32'hC000_0000);
    winRead(32'h24, rd); chk("R5 self-refresh rise", rd, 32'h4000_0000);

    // R8 bank 3 mask and slice
    busWrite(10'h010, 32'h4C);
    busWrite(10'h011, 32'h1234_5678);
    chk("R8 bank3 slice", bankWords[127:96], 32'h1214_4000);

    // R12 write visible only after the edge
    busWrite(10'h010, 32'h10);
    busWrite(10'h011, 32'hCAFE_F00D);
    busNum = 10'h011; busWdata = 32'h0000_0000; busWr = 1'b1;
    #1; chk("R12 before edge", busRdata, 32'hCAFE_F00D);
    @(negedge clk); busWr = 1'b0;
    #1; chk("R12 after edge", busRdata, 32'h0000_0000);

    // R1 write to an unmapped bus number is ignored
    @(negedge clk);
    busWrite(10'h055, 32'h0000_0020);
    busRead(10'h010, rd); chk("R1 pointer unchanged", rd, 32'h10);
    busRead(10'h011, rd); chk("R1 window unchanged", rd, 32'h0);

    // R3 second status word too
    winRead(32'h08, rd); chk("R3 err1 zero", rd, 32'd0);

    // R11 reset mid-run
    busWrite(10'h010, 32'h98);
    busWrite(10'h011, 32'h0000_1000);
    chk("R11 irq before reset", {31'd0, eccIrq}, 32'd1);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R11 irq after reset", {31'd0, eccIrq}, 32'd0);
    chk("R11 enable after reset", {31'd0, ctlEnable}, 32'd0);
    chk("R11 bank3 after reset", bankWords[127:96], 32'd0);
    winRead(32'h24, rd); chk("R11 status after reset", rd, 32'd0);
    winRead(32'h20, rd); chk("R11 config after reset", rd, 32'h0080_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule